// File: doc/BRIEF.md
# PLL Divider Control Register with Sticky Lock

This block is one 16-bit control and status register for the programmable feedback divider of a PLL. The divider is a dual-modulus counter. The register holds the two divider values. The 8-bit P value sits in the low byte and the 4-bit Q value sits in bits 11:8. Both values drive output ports continuously, so the counter logic can use them directly. A combinational checker compares the two values against the legal ranges and raises a flag when the pair is valid. An illegal pair is still stored, and the flag shows that it is illegal.

Bit 14 is a lock. Software can set it but cannot clear it. Once it is set, the two divider fields can no longer be changed until the next reset. Bit 15 gives software a live view of the slow 32 kHz reference clock. That clock is asynchronous to the bus, so it is resynchronised before it is read. Bits 13:12 are reserved and always read as zero. The register sits on a simple synchronous bus that has an address decode, per-byte write enables and registered read data.

Top module: `pll_div_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are P = 0x47, Q = 3, the lock is clear and `cfg_legal` is 1. With the reference low, a read returns 0x0347.
- R2: A write with both byte enables set and a matching address stores `wdata[7:0]` as P and `wdata[11:8]` as Q. A later read returns these values in the same bit positions.
- R3: Byte enable bit 0 covers bits 7:0 (P). Byte enable bit 1 covers bits 15:8 (Q and the lock bit 14). A lane whose enable is clear is left unchanged.
- R4: A write that has bit 14 set and byte enable bit 1 set sets the lock. If the lock was clear before that write, the Q and P values in the same write are also stored.
- R5: While the lock is set, writes to P and Q are ignored. Writing 0 to bit 14 does not clear the lock. Only reset clears it.
- R6: Bits 13:12 always read as 0, whatever value was written to them.
- R7: Bit 15 reads the level of the asynchronous reference input after a two-flop synchroniser. A read strobed on the first rising edge after the input changes still shows the old level. A read strobed on the third or a later edge shows the new level. Writes to bit 15 have no effect.
- R8: `cfg_legal` is 1 exactly when 1 < Q < 14 and P > Q + 1, with P and Q read as unsigned values. An illegal pair is still stored and read back.
- R9: Read data appears on `rdata` in the cycle after the read strobe. A read of any address other than `REG_ADDR` returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Bus access strobe, one cycle per access |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Access address, compared with REG_ADDR |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| rdata | output | 16 | Registered read data |
| ref_async | input | 1 | 32 kHz reference clock, asynchronous to clk |
| p_value | output | 8 | Current P divider value |
| q_value | output | 4 | Current Q divider value |
| cfg_legal | output | 1 | 1 when the current P/Q pair meets both range rules |

## Verification
The hardest state to reach is a locked register, because the lock can only be cleared by reset. Any scenario that runs after the lock is set would see frozen fields. The bench therefore runs the lock scenario last. It sets the lock in the same write that loads new values, so both lock behaviours are covered in one write. It then tries full-width writes and single-lane writes, including writes of 0 to the lock bit. Finally it applies reset and checks that the lock has cleared. The synchroniser latency is checked by changing the reference input on the same edge as a read strobe, and then reading again later.

// File: rtl/pllc_pkg.sv
// Package: shared widths, field positions and reset values for the
// PLL divider control register. Assumes a 16-bit register of two byte lanes.
package pllc_pkg;
    localparam int DATA_W   = 16;
    localparam int LANES    = DATA_W / 8;
    localparam int P_W      = 8;
    localparam int Q_W      = 4;
    localparam int Q_LSB    = 8;
    localparam int LOCK_BIT = 14;
    localparam int REF_BIT  = 15;
    localparam logic [P_W-1:0] P_RESET = 8'h47;
    localparam logic [Q_W-1:0] Q_RESET = 4'h3;
    localparam int Q_LOW_EXCL  = 1;
    localparam int Q_HIGH_EXCL = 14;
endpackage

// File: rtl/pllc_sync.sv
// Module: multi-flop synchroniser for the asynchronous reference input.
// Assumes STAGES >= 2. The output is the last flop of the chain.
module pllc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_async,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Purpose: shift the async level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din_async};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pllc_field_regs.sv
// Module: P/Q divider storage with per-lane write and a set-only lock.
// Assumes wr_hit is already address-decoded and lasts one cycle per write.
module pllc_field_regs
    import pllc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [P_W-1:0]    p_o,
    output logic [Q_W-1:0]    q_o,
    output logic              lock_o
);
    logic [P_W-1:0] p_q;
    logic [Q_W-1:0] q_q;
    logic           lock_q;

    // Purpose: update the fields lane by lane; the lock only ever sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= P_RESET;
            q_q    <= Q_RESET;
            lock_q <= 1'b0;
        end else if (wr_hit) begin
            if (be[0] && !lock_q) p_q <= wdata[P_W-1:0];
            if (be[1]) begin
                if (!lock_q)          q_q    <= wdata[Q_LSB +: Q_W];
                if (wdata[LOCK_BIT])  lock_q <= 1'b1;
            end
        end
    end

    assign p_o    = p_q;
    assign q_o    = q_q;
    assign lock_o = lock_q;

    // R5: the lock never falls without reset.
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R5: the fields are frozen while locked.
    a_r5_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(p_q) && $stable(q_q)));
    // R3: a disabled upper lane keeps Q.
    a_r3_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !be[1]) |=> $stable(q_q));
    // R3: a disabled lower lane keeps P.
    a_r3_lower_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !be[0]) |=> $stable(p_q));
endmodule

// File: rtl/pllc_range_chk.sv
// Module: combinational legality check of the divider pair.
// Assumes unsigned P and Q; P is compared against Q+1 in a widened sum.
module pllc_range_chk
    import pllc_pkg::*;
(
    input  logic [P_W-1:0] p_i,
    input  logic [Q_W-1:0] q_i,
    output logic           legal_o
);
    localparam int CMP_W = P_W + 1;
    logic q_ok;
    logic p_ok;

    // Purpose: evaluate both range rules.
    always_comb begin
        q_ok    = (int'(q_i) > Q_LOW_EXCL) && (int'(q_i) < Q_HIGH_EXCL);
        p_ok    = {1'b0, p_i} > (CMP_W'(q_i) + CMP_W'(1));
        legal_o = q_ok && p_ok;
    end
endmodule

// File: rtl/pll_div_ctrl.sv
// Module: top of the PLL divider control register. Decodes the bus,
// registers the read data and joins storage, synchroniser and range check.
// Assumes single-cycle accesses marked by sel.
module pll_div_ctrl
    import pllc_pkg::*;
#(
    parameter int              ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 4'h2,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [1:0]        be,
    output logic [15:0]       rdata,
    input  logic              ref_async,
    output logic [7:0]        p_value,
    output logic [3:0]        q_value,
    output logic              cfg_legal
);
    logic hit;
    logic wr_hit;
    logic rd_any;
    logic ref_lvl;
    logic lock;
    logic [DATA_W-1:0] view;

    assign hit    = sel && (addr == REG_ADDR);
    assign wr_hit = hit && wr_en;
    assign rd_any = sel && !wr_en;

    pllc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din_async(ref_async),
        .dout     (ref_lvl)
    );

    pllc_field_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_hit),
        .be    (be),
        .wdata (wdata),
        .p_o   (p_value),
        .q_o   (q_value),
        .lock_o(lock)
    );

    pllc_range_chk u_chk (
        .p_i    (p_value),
        .q_i    (q_value),
        .legal_o(cfg_legal)
    );

    // Purpose: assemble the readable image; reserved bits are tied low.
    always_comb begin
        view                   = '0;
        view[P_W-1:0]          = p_value;
        view[Q_LSB +: Q_W]     = q_value;
        view[LOCK_BIT]         = lock;
        view[REF_BIT]          = ref_lvl;
    end

    // Purpose: capture read data one cycle after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_any) rdata <= (addr == REG_ADDR) ? view : '0;
    end

    // R6: reserved bits never read as set.
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> (rdata[13:12] == 2'b00));
    // R9: a missed address reads zero.
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (addr != REG_ADDR)) |=> (rdata == 16'h0000));
    // R8: a legal pair implies P of at least 4.
    a_r8_legal_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_legal |-> (p_value >= 8'd4));
endmodule

// File: tb/sim_pll_div_ctrl.sv
module sim_pll_div_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [1:0]  be = 2'b00;
    logic [15:0] rdata;
    logic        ref_async = 1'b0;
    logic [7:0]  p_value;
    logic [3:0]  q_value;
    logic        cfg_legal;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] rd;

    localparam logic [3:0] RA = 4'h2;

    always #10 clk = ~clk;

    pll_div_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .ref_async(ref_async),
        .p_value(p_value), .q_value(q_value), .cfg_legal(cfg_legal)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0; be = 2'b00;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = a;
        @(negedge clk); sel = 1'b0; d = rdata;
    endtask

    task automatic t_reset();
        chk("R1", "P", {8'h0, p_value}, 16'h0047);
        chk("R1", "Q", {12'h0, q_value}, 16'h0003);
        chk("R1", "legal", {15'h0, cfg_legal}, 16'h0001);
        bus_rd(RA, rd); chk("R1", "read", rd, 16'h0347);
    endtask

    task automatic t_full_write();
        bus_wr(RA, 16'h0A80, 2'b11);
        chk("R2", "P", {8'h0, p_value}, 16'h0080);
        chk("R2", "Q", {12'h0, q_value}, 16'h000A);
        bus_rd(RA, rd); chk("R2", "read", rd, 16'h0A80);
    endtask

    task automatic t_byte_lanes();
        bus_wr(RA, 16'h0512, 2'b01); bus_rd(RA, rd);
        chk("R3", "low lane only", rd, 16'h0A12);
        bus_wr(RA, 16'h0C99, 2'b10); bus_rd(RA, rd);
        chk("R3", "high lane only", rd, 16'h0C12);
        bus_wr(RA, 16'h4055, 2'b01); bus_rd(RA, rd);
        chk("R3", "lock bit outside lane", rd, 16'h0C55);
    endtask

    task automatic t_reserved();
        bus_wr(RA, 16'h3456, 2'b11); bus_rd(RA, rd);
        chk("R6", "reserved bits", rd, 16'h0456);
        bus_wr(RA, 16'h8456, 2'b11); bus_rd(RA, rd);
        chk("R7", "bit15 write ignored", rd, 16'h0456);
    endtask

    task automatic t_range();
        bus_wr(RA, 16'h0204, 2'b11);
        chk("R8", "Q2 P4", {15'h0, cfg_legal}, 16'h0001);
        bus_wr(RA, 16'h0203, 2'b11);
        chk("R8", "Q2 P3", {15'h0, cfg_legal}, 16'h0000);
        bus_rd(RA, rd); chk("R8", "illegal stored", rd, 16'h0203);
        bus_wr(RA, 16'h0140, 2'b11);
        chk("R8", "Q1", {15'h0, cfg_legal}, 16'h0000);
        bus_wr(RA, 16'h0EFF, 2'b11);
        chk("R8", "Q14", {15'h0, cfg_legal}, 16'h0000);
        bus_wr(RA, 16'h0D0F, 2'b11);
        chk("R8", "Q13 P15", {15'h0, cfg_legal}, 16'h0001);
        bus_wr(RA, 16'h0D0E, 2'b11);
        chk("R8", "Q13 P14", {15'h0, cfg_legal}, 16'h0000);
    endtask

    task automatic t_decode();
        bus_wr(RA, 16'h0560, 2'b11);
        bus_wr(4'h5, 16'h0777, 2'b11); bus_rd(RA, rd);
        chk("R9", "foreign write", rd, 16'h0560);
        bus_rd(4'h5, rd); chk("R9", "foreign read", rd, 16'h0000);
    endtask

    task automatic t_ref();
        @(negedge clk); ref_async = 1'b1; sel = 1'b1; wr_en = 1'b0; addr = RA;
        @(negedge clk); sel = 1'b0;
        chk("R7", "first edge old level", {15'h0, rdata[15]}, 16'h0000);
        @(negedge clk); @(negedge clk);
        bus_rd(RA, rd); chk("R7", "high level", rd, 16'h8560);
        @(negedge clk); ref_async = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        bus_rd(RA, rd); chk("R7", "low level", rd, 16'h0560);
    endtask

    task automatic t_lock();
        bus_wr(RA, 16'h4B60, 2'b11); bus_rd(RA, rd);
        chk("R4", "lock with new Q", rd, 16'h4B60);
        bus_wr(RA, 16'h0305, 2'b11); bus_rd(RA, rd);
        chk("R5", "full write locked", rd, 16'h4B60);
        bus_wr(RA, 16'h00AA, 2'b01); bus_rd(RA, rd);
        chk("R5", "low lane locked", rd, 16'h4B60);
        chk("R5", "P port", {8'h0, p_value}, 16'h0060);
        do_reset(); bus_rd(RA, rd);
        chk("R5", "reset clears lock", rd, 16'h0347);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_full_write();
        t_byte_lanes();
        t_reserved();
        t_range();
        t_decode();
        t_ref();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule